// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter held as a low and a high byte. In timer mode it advances on a one-cycle enable from the chip's instruction-rate clock divider. In counter mode it advances on rising edges of an external input. The external input is a sampled digital signal taken from one of two pins. A two-bit field selects a prescaler ratio of 1, 2, 4 or 8, and the prescaler sits in front of an optional two-flop synchronizer.

Software can load either byte at any time. It can also clear a sticky wrap flag. A run control gates counting. A sleep input halts the synchronized counter path, while the prescaler keeps accumulating edges.

Top module: `tmr16_presc`

## Requirements
- R1: After reset, `count_o` is 0x0000 and `ovf_o` is 0.
- R2: With `src_ext_i`=0, `run_i`=1 and a ratio of 1, each cycle with `tick_i`=1 adds one to `count_o`. The new value is visible after the next clock edge, whatever the value of `async_i`.
- R3: `ps_sel_i` selects a division ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The counter advances once per that many prescaler input events.
- R4: Once counter mode is enabled (`run_i`=1 and `src_ext_i`=1), no rising edge counts until a falling edge of the selected input has been sampled.
- R5: With `async_i`=1 in counter mode, an armed rising edge sampled at a clock edge updates `count_o` at that same edge. `sleep_i` does not stop this path.
- R6: With `async_i`=0 in counter mode, the same update arrives two clock edges later than on the unsynchronized path.
- R7: With `async_i`=0 and `sleep_i`=1 in counter mode, `count_o` does not advance. The prescaler still counts edges during sleep, and those edges carry over after wake.
- R8: `pin_sel_i`=0 takes edges from `ext_a_i` and `pin_sel_i`=1 takes them from `ext_b_i`. The other pin is ignored.
- R9: An increment from 0xFFFF to 0x0000 sets `ovf_o`. The flag stays set until `ovf_clr_i` is pulsed.
- R10: `wr_lo_i` or `wr_hi_i` loads `wr_data_i` into that byte at the next edge and resets the prescaler count. No increment occurs in a cycle with a write.
- R11: With `run_i`=0, `count_o` does not change except by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-rate count enable for timer mode |
| ext_a_i | input | 1 | External edge input, pin A |
| ext_b_i | input | 1 | External edge input, pin B |
| pin_sel_i | input | 1 | 1 selects pin B, 0 selects pin A |
| src_ext_i | input | 1 | 1 selects counter mode, 0 selects timer mode |
| async_i | input | 1 | 1 bypasses the synchronizer in counter mode |
| run_i | input | 1 | Counting enable |
| sleep_i | input | 1 | Sleep state; halts the synchronized path |
| ps_sel_i | input | 2 | Prescaler ratio select |
| wr_lo_i | input | 1 | Load low byte |
| wr_hi_i | input | 1 | Load high byte |
| wr_data_i | input | 8 | Byte to load |
| ovf_clr_i | input | 1 | Clears the wrap flag |
| count_o | output | 16 | Current count {high, low} |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
Timer ticks, unsynchronized edges and writes take effect at the first clock edge that samples them. Synchronized edges land two edges later. The bench drives inputs on falling edges and queues each expectation with the cycle number in which it is due. Its monitor compares at the falling edge of exactly that cycle. For the synchronized path, one item checks that the count is still unchanged one cycle before the update and a second checks the new value.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // Prescaler ratio encoding (value of ps_sel_i)
  typedef enum logic [1:0] {
    DIV_1 = 2'd0,
    DIV_2 = 2'd1,
    DIV_4 = 2'd2,
    DIV_8 = 2'd3
  } ps_ratio_e;

  localparam int HALVES = 2;
endpackage

// File: rtl/tmr16_edge_arm.sv
module tmr16_edge_arm (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  input  logic arm_en_i,
  output logic rise_o
);
  logic ext_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b0;
      armed <= 1'b0;
    end else begin
      ext_q <= ext_i;
      if (!arm_en_i)
        armed <= 1'b0;
      else if (ext_q && !ext_i)
        armed <= 1'b1;
    end
  end

  // counts only after a falling edge has been seen while enabled
  assign rise_o = arm_en_i && armed && !ext_q && ext_i;
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            in_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            out_o
);
  localparam int DIV_BITS = (1 << PS_W) - 1;

  logic [DIV_BITS-1:0] cnt;
  logic [DIV_BITS-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_BITS; i++)
      mask[i] = (i < int'(sel_i));
  end

  assign out_o = in_i && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt <= '0;
    else if (in_i)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic pulse_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst)
      chain <= '0;
    else
      chain <= {chain[STAGES-1:0], d_i};
  end

  assign pulse_o = chain[STAGES-1] && !chain[STAGES];
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int CNT_W = HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  logic [HALVES-1:0]             wr_en;
  logic [HALVES-1:0][HALF_W-1:0] half_q;
  logic [HALVES:0]               carry;

  assign wr_en    = {wr_hi_i, wr_lo_i};
  assign carry[0] = inc_i && !(|wr_en);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign carry[h+1] = carry[h] && (&half_q[h]);

    always_ff @(posedge clk) begin
      if (rst)
        half_q[h] <= '0;
      else if (wr_en[h])
        half_q[h] <= wr_data_i;
      else if (carry[h])
        half_q[h] <= half_q[h] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ovf_o <= 1'b0;
    else if (carry[HALVES])
      ovf_o <= 1'b1;
    else if (ovf_clr_i)
      ovf_o <= 1'b0;
  end

  assign count_o = half_q;
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
  parameter int HALF_W      = 8,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ext_a_i,
  input  logic              ext_b_i,
  input  logic              pin_sel_i,
  input  logic              src_ext_i,
  input  logic              async_i,
  input  logic              run_i,
  input  logic              sleep_i,
  input  logic [PS_W-1:0]   ps_sel_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              ovf_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  logic ext_sel, ext_rise, ps_in, ps_out, sync_pulse, inc;

  assign ext_sel = pin_sel_i ? ext_b_i : ext_a_i;

  tmr16_edge_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .ext_i   (ext_sel),
    .arm_en_i(run_i && src_ext_i),
    .rise_o  (ext_rise)
  );

  assign ps_in = run_i && (src_ext_i ? ext_rise : tick_i);

  tmr16_prescaler #(.PS_W(PS_W)) u_ps (
    .clk  (clk),
    .rst  (rst),
    .clr_i(wr_lo_i || wr_hi_i),
    .in_i (ps_in),
    .sel_i(ps_sel_i),
    .out_o(ps_out)
  );

  tmr16_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (ps_out && src_ext_i && !async_i),
    .pulse_o(sync_pulse)
  );

  always_comb begin
    if (!src_ext_i || async_i)
      inc = ps_out;
    else
      inc = sync_pulse && !sleep_i;
  end

  tmr16_core #(.HALF_W(HALF_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .inc_i    (run_i && inc),
    .wr_lo_i  (wr_lo_i),
    .wr_hi_i  (wr_hi_i),
    .wr_data_i(wr_data_i),
    .ovf_clr_i(ovf_clr_i),
    .count_o  (count_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/tmr16_presc_chk.sv
module tmr16_presc_chk #(
  parameter int HALF_W = 8,
  parameter int PS_W   = 2,
  localparam int CNT_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              run_i,
  input logic              sleep_i,
  input logic              src_ext_i,
  input logic              async_i,
  input logic              wr_lo_i,
  input logic              wr_hi_i,
  input logic [HALF_W-1:0] wr_data_i,
  input logic              ovf_clr_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              ovf_o
);
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(count_o) == {CNT_W{1'b1}} && count_o == '0 && !$past(wr_lo_i || wr_hi_i))
    |-> ovf_o);

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R11
  run_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> (count_o == $past(count_o)));

  // R7
  sleep_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && src_ext_i && !async_i && !wr_lo_i && !wr_hi_i)
    |=> (count_o == $past(count_o)));

  // R10
  wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo_i |=> (count_o[HALF_W-1:0] == $past(wr_data_i)));

  // R10
  wr_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hi_i |=> (count_o[CNT_W-1:HALF_W] == $past(wr_data_i)));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo_i && !wr_hi_i)
    |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));
endmodule

bind tmr16_presc tmr16_presc_chk #(.HALF_W(HALF_W), .PS_W(PS_W)) u_chk (.*);

// File: tb/tmr16_presc_tb.sv
module tmr16_presc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 0, ext_a_i = 0, ext_b_i = 0, pin_sel_i = 0;
  logic        src_ext_i = 0, async_i = 0, run_i = 0, sleep_i = 0;
  logic [1:0]  ps_sel_i = 0;
  logic        wr_lo_i = 0, wr_hi_i = 0, ovf_clr_i = 0;
  logic [7:0]  wr_data_i = 0;
  logic [15:0] count_o;
  logic        ovf_o;

  tmr16_presc u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    int          due;
    logic [15:0] cnt;
    logic        ovf;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued items in the cycle they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_checks++;
      if (it.due != cyc || count_o !== it.cnt || ovf_o !== it.ovf) begin
        n_fail++;
        $display("FAIL %s: count=%h ovf=%b expected count=%h ovf=%b (cycle %0d)",
                 it.tag, count_o, ovf_o, it.cnt, it.ovf, cyc);
      end
    end
  end

  task automatic push(input string tag, input int due, input logic [15:0] c, input logic o);
    item_t it;
    it.tag = tag; it.due = due; it.cnt = c; it.ovf = o;
    q.push_back(it);
  endtask

  task automatic expect_now(input string tag, input logic [15:0] c, input logic o);
    push(tag, cyc + 1, c, o);
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick_i = 1; end
    @(negedge clk); tick_i = 0;
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    @(negedge clk); wr_data_i = d; if (hi) wr_hi_i = 1; else wr_lo_i = 1;
    @(negedge clk); wr_lo_i = 0; wr_hi_i = 0;
  endtask

  task automatic clear_cnt();
    wr_byte(0, 8'h00); wr_byte(1, 8'h00);
  endtask

  task automatic ext_pulse(input bit use_b);
    @(negedge clk); if (use_b) ext_b_i = 1; else ext_a_i = 1;
    @(negedge clk); if (use_b) ext_b_i = 0; else ext_a_i = 0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expect_now("R1 reset state", 16'h0000, 1'b0);

    // R2 timer mode, ratio 1
    run_i = 1; src_ext_i = 0; async_i = 0; ps_sel_i = 2'd0;
    ticks(5);
    expect_now("R2 five ticks", 16'd5, 1'b0);
    @(negedge clk); tick_i = 1; push("R2 next-edge latency", cyc + 1, 16'd6, 1'b0);
    @(negedge clk); tick_i = 0;
    settle(2);
    expect_now("R2 single tick", 16'd6, 1'b0);

    // R3 prescaler ratios
    ps_sel_i = 2'd2; clear_cnt();
    ticks(8);
    expect_now("R3 div4 eight ticks", 16'd2, 1'b0);
    ps_sel_i = 2'd3; clear_cnt();
    ticks(7);
    expect_now("R3 div8 seven ticks", 16'd0, 1'b0);
    ticks(1);
    expect_now("R3 div8 eighth tick", 16'd1, 1'b0);
    ps_sel_i = 2'd1; clear_cnt();
    ticks(3);
    expect_now("R3 div2 three ticks", 16'd1, 1'b0);

    // R10 writes load and clear the prescaler
    ps_sel_i = 2'd2; clear_cnt();
    ticks(3);
    wr_byte(0, 8'h10);
    ticks(1);
    expect_now("R10 low load, prescaler cleared", 16'h0010, 1'b0);
    ticks(3);
    expect_now("R10 fourth tick after load", 16'h0011, 1'b0);
    wr_byte(1, 8'hAB);
    expect_now("R10 high load", 16'hAB11, 1'b0);

    // R9 wrap flag
    ps_sel_i = 2'd0;
    wr_byte(0, 8'hFE); wr_byte(1, 8'hFF);
    ticks(1);
    expect_now("R9 at top", 16'hFFFF, 1'b0);
    ticks(1);
    expect_now("R9 wrap sets flag", 16'h0000, 1'b1);
    ticks(2);
    expect_now("R9 flag sticky", 16'h0002, 1'b1);
    @(negedge clk); ovf_clr_i = 1;
    @(negedge clk); ovf_clr_i = 0;
    expect_now("R9 flag cleared", 16'h0002, 1'b0);

    // R11 run off
    run_i = 0;
    ticks(4);
    expect_now("R11 ticks ignored when off", 16'h0002, 1'b0);

    // R4 arming, pin A, unsynchronized
    src_ext_i = 1; async_i = 1; pin_sel_i = 0; clear_cnt();
    @(negedge clk); run_i = 1;
    ext_pulse(0);
    settle(2);
    expect_now("R4 first rise not counted", 16'd0, 1'b0);
    ext_pulse(0);
    settle(2);
    expect_now("R4 rise after fall counted", 16'd1, 1'b0);
    @(negedge clk); run_i = 0; ext_a_i = 1;
    @(negedge clk); run_i = 1;
    settle(3);
    expect_now("R4 high at enable not counted", 16'd1, 1'b0);
    @(negedge clk); ext_a_i = 0;
    ext_pulse(0);
    settle(2);
    expect_now("R4 count after fall then rise", 16'd2, 1'b0);

    // R5 unsynchronized latency and sleep
    @(negedge clk); ext_a_i = 1; push("R5 same-edge update", cyc + 1, 16'd3, 1'b0);
    @(negedge clk); ext_a_i = 0;
    settle(2);
    sleep_i = 1;
    ext_pulse(0); ext_pulse(0);
    settle(2);
    expect_now("R5 sleep does not stop async path", 16'd5, 1'b0);
    sleep_i = 0;

    // R6 synchronized latency
    async_i = 0;
    settle(2);
    @(negedge clk); ext_a_i = 1;
    push("R6 not yet updated", cyc + 2, 16'd5, 1'b0);
    push("R6 two edges later", cyc + 3, 16'd6, 1'b0);
    @(negedge clk); ext_a_i = 0;
    settle(4);

    // R7 sleep stops the synchronized path, prescaler keeps counting
    sleep_i = 1;
    ext_pulse(0); ext_pulse(0);
    settle(6);
    expect_now("R7 no count in sleep", 16'd6, 1'b0);
    ps_sel_i = 2'd2; clear_cnt();
    ext_pulse(0); ext_pulse(0); ext_pulse(0);
    settle(6);
    sleep_i = 0;
    ext_pulse(0);
    settle(6);
    expect_now("R7 prescaler kept sleep edges", 16'd1, 1'b0);

    // R8 pin B selected, pin A ignored
    async_i = 1; ps_sel_i = 2'd0;
    @(negedge clk); run_i = 0; pin_sel_i = 1;
    clear_cnt();
    @(negedge clk); run_i = 1;
    ext_pulse(1);
    ext_pulse(0); ext_pulse(0);
    settle(2);
    expect_now("R8 pin A ignored", 16'd0, 1'b0);
    ext_pulse(1);
    settle(2);
    expect_now("R8 pin B counted", 16'd1, 1'b0);

    settle(4);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    done = 1;
    report();
    $finish;
  end
endmodule